// File: doc/BRIEF.md
# Outstanding Miss Tracker

This block keeps track of cache misses that are waiting on memory, so that a non-blocking cache can go on serving accesses while refills are in flight. Each miss arrives with the block address that missed, the cache block location the refill will land in, the destination register and the word offset inside the block. The tracker holds a small table of entries. Each entry stands for one block being fetched and carries a list of waiting targets.

The first miss to a block takes a free entry and produces one memory request that carries the entry number. Later misses to the same block, made while that fetch is still pending, are appended to the entry's target list and send nothing to memory. When memory returns a fill tagged with an entry number, the tracker hands the waiting targets back one per cycle in the order they arrived, then frees the entry. Misses are refused through back-pressure when no entry is free or when the matching entry's target list is full. The data arrays, the memory and the data path are outside the block.

Top module: `miss_tracker`

## Requirements
- R1: After reset the tracker is empty: `req_valid` and `rel_valid` are low, `fill_ready` is high and any miss is accepted (`miss_ready` high).
- R2: A miss whose block address matches no entry still waiting on memory is primary. It takes the lowest-numbered free entry, and that entry then raises exactly one memory request carrying the block address and the entry number. When several requests are waiting, the lowest-numbered entry is presented first.
- R3: A miss whose block address matches an entry still waiting on memory is secondary. It is accepted and added as a target of that entry, and it produces no further memory request.
- R4: At most `NUM_ENT` blocks are tracked. With every entry busy, a primary miss is stalled (`miss_ready` low), while a secondary miss to a tracked block is still accepted.
- R5: An entry holds at most `NUM_TGT` targets. A secondary miss to an entry that already has that many is stalled.
- R6: After a fill for an entry is accepted, its targets are presented on the release port starting in the next cycle, one per handshake, in arrival order. Each release carries the register, word offset and cache location, and the last release has `rel_last` high.
- R7: After the last release of an entry, the entry is free. A new miss to the same block address is then primary and raises a new request.
- R8: A miss to a block whose fill has been accepted but whose targets are still being released is treated as primary. It takes a different entry and raises a new request.
- R9: While targets are being released, `fill_ready` is low.
- R10: While `rel_valid` is high and `rel_ready` is low, the release outputs hold their values. A raised `req_valid` stays high until a request handshake happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A miss is offered |
| miss_ready | output | 1 | The offered miss is taken this cycle |
| miss_addr | input | ADDR_W | Block address of the miss |
| miss_loc | input | LOC_W | Cache block location for the refill |
| miss_reg | input | REG_W | Destination register |
| miss_off | input | OFF_W | Word offset inside the block |
| req_valid | output | 1 | A memory request is offered |
| req_ready | input | 1 | Memory takes the request |
| req_addr | output | ADDR_W | Block address to fetch |
| req_id | output | ID_W | Entry number the fill must carry |
| fill_valid | input | 1 | Memory returns a fill |
| fill_ready | output | 1 | A fill can be taken |
| fill_id | input | ID_W | Entry number of the fill |
| rel_valid | output | 1 | A waiting target is offered |
| rel_ready | input | 1 | The target is taken |
| rel_reg | output | REG_W | Register of the released target |
| rel_off | output | OFF_W | Word offset of the released target |
| rel_loc | output | LOC_W | Cache location of the block |
| rel_last | output | 1 | Final target of this entry |

## Verification
A wrong match bit shows at the request port right away. A secondary miss that was wrongly taken as primary raises an extra request in the next cycle, and a primary miss that was wrongly merged raises none. A wrong target count or write slot stays hidden until the entry's fill. It then appears as a reordered, missing or extra release, or as `rel_last` in the wrong place. A free flag that is not cleared shows up later: a stall with a free entry available, or a freed block that is not requested again. The bench therefore always follows a fill through to its last release and then probes the same address once more.

// File: rtl/miss_tracker.sv
module miss_tracker #(
  parameter int ADDR_W  = 26,
  parameter int LOC_W   = 10,
  parameter int REG_W   = 5,
  parameter int OFF_W   = 2,
  parameter int NUM_ENT = 4,
  parameter int NUM_TGT = 4,
  localparam int ID_W   = $clog2(NUM_ENT),
  localparam int TI_W   = $clog2(NUM_TGT),
  localparam int CNT_W  = $clog2(NUM_TGT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [LOC_W-1:0]  miss_loc,
  input  logic [REG_W-1:0]  miss_reg,
  input  logic [OFF_W-1:0]  miss_off,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [ID_W-1:0]   req_id,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [ID_W-1:0]   fill_id,
  output logic              rel_valid,
  input  logic              rel_ready,
  output logic [REG_W-1:0]  rel_reg,
  output logic [OFF_W-1:0]  rel_off,
  output logic [LOC_W-1:0]  rel_loc,
  output logic              rel_last
);

  logic [NUM_ENT-1:0] ent_val, ent_sent, ent_fill;
  logic [ADDR_W-1:0]  ent_addr [NUM_ENT];
  logic [LOC_W-1:0]   ent_loc  [NUM_ENT];
  logic [CNT_W-1:0]   ent_cnt  [NUM_ENT];
  logic [REG_W-1:0]   t_reg    [NUM_ENT][NUM_TGT];
  logic [OFF_W-1:0]   t_off    [NUM_ENT][NUM_TGT];

  logic               draining;
  logic [ID_W-1:0]    drn_id;
  logic [CNT_W-1:0]   drn_ptr;

  logic               hit, any_free, tgt_full, do_miss, do_req, do_fill, do_rel;
  logic [ID_W-1:0]    hit_id, free_id, pick_id, wr_id;
  logic [CNT_W-1:0]   wr_slot;

  always_comb begin
    hit = 1'b0;
    hit_id = '0;
    for (int i = 0; i < NUM_ENT; i++)
      if (ent_val[i] && !ent_fill[i] && ent_addr[i] == miss_addr) begin
        hit = 1'b1;
        hit_id = ID_W'(i);
      end
  end

  always_comb begin
    free_id = '0;
    pick_id = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!ent_val[i]) free_id = ID_W'(i);
      if (ent_val[i] && !ent_sent[i]) pick_id = ID_W'(i);
    end
  end

  assign any_free   = ~&ent_val;
  assign tgt_full   = ent_cnt[hit_id] == CNT_W'(NUM_TGT);
  assign miss_ready = hit ? !tgt_full : any_free;
  assign do_miss    = miss_valid && miss_ready;
  assign wr_id      = hit ? hit_id : free_id;
  assign wr_slot    = hit ? ent_cnt[hit_id] : '0;

  assign req_valid  = |(ent_val & ~ent_sent);
  assign req_id     = pick_id;
  assign req_addr   = ent_addr[pick_id];
  assign do_req     = req_valid && req_ready;

  assign fill_ready = !draining;
  assign do_fill    = fill_valid && fill_ready;

  assign rel_valid  = draining;
  assign rel_reg    = t_reg[drn_id][drn_ptr[TI_W-1:0]];
  assign rel_off    = t_off[drn_id][drn_ptr[TI_W-1:0]];
  assign rel_loc    = ent_loc[drn_id];
  assign rel_last   = (drn_ptr + CNT_W'(1)) == ent_cnt[drn_id];
  assign do_rel     = rel_valid && rel_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_val  <= '0;
      ent_sent <= '0;
      ent_fill <= '0;
      draining <= 1'b0;
      drn_id   <= '0;
      drn_ptr  <= '0;
      for (int i = 0; i < NUM_ENT; i++) ent_cnt[i] <= '0;
    end else begin
      if (do_miss) begin
        ent_cnt[wr_id] <= wr_slot + CNT_W'(1);
        if (!hit) begin
          ent_val[wr_id]  <= 1'b1;
          ent_sent[wr_id] <= 1'b0;
          ent_fill[wr_id] <= 1'b0;
        end
      end
      if (do_req) ent_sent[pick_id] <= 1'b1;
      if (do_fill) begin
        ent_fill[fill_id] <= 1'b1;
        draining <= 1'b1;
        drn_id   <= fill_id;
        drn_ptr  <= '0;
      end
      if (do_rel) begin
        if (rel_last) begin
          draining <= 1'b0;
          ent_val[drn_id]  <= 1'b0;
          ent_fill[drn_id] <= 1'b0;
        end else begin
          drn_ptr <= drn_ptr + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_miss) begin
      t_reg[wr_id][wr_slot[TI_W-1:0]] <= miss_reg;
      t_off[wr_id][wr_slot[TI_W-1:0]] <= miss_off;
      if (!hit) begin
        ent_addr[wr_id] <= miss_addr;
        ent_loc[wr_id]  <= miss_loc;
      end
    end
  end

endmodule

// File: rtl/miss_tracker_chk.sv
module miss_tracker_chk #(
  parameter int LOC_W = 10,
  parameter int REG_W = 5,
  parameter int OFF_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             fill_ready,
  input logic             rel_valid,
  input logic             rel_ready,
  input logic [REG_W-1:0] rel_reg,
  input logic [OFF_W-1:0] rel_off,
  input logic [LOC_W-1:0] rel_loc,
  input logic             rel_last
);

  AST_REL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && !rel_ready |=> rel_valid && $stable(rel_reg) && $stable(rel_off)
                                && $stable(rel_loc) && $stable(rel_last)); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid); // R10

  AST_FILL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> !fill_ready); // R9

  AST_DRAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && rel_ready && rel_last |=> !rel_valid && fill_ready); // R6

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !rel_valid && !req_valid); // R1

endmodule

bind miss_tracker miss_tracker_chk #(.LOC_W(LOC_W), .REG_W(REG_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/test_miss_tracker.sv
`timescale 1ns/1ps
module test_miss_tracker;
  localparam int ADDR_W = 26, LOC_W = 10, REG_W = 5, OFF_W = 2, ID_W = 2;

  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, req_ready = 0, fill_valid = 0, rel_ready = 0;
  logic [ADDR_W-1:0] miss_addr = '0;
  logic [LOC_W-1:0]  miss_loc = '0;
  logic [REG_W-1:0]  miss_reg = '0;
  logic [OFF_W-1:0]  miss_off = '0;
  logic [ID_W-1:0]   fill_id = '0;
  logic miss_ready, req_valid, fill_ready, rel_valid, rel_last;
  logic [ADDR_W-1:0] req_addr;
  logic [ID_W-1:0]   req_id;
  logic [REG_W-1:0]  rel_reg;
  logic [OFF_W-1:0]  rel_off;
  logic [LOC_W-1:0]  rel_loc;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  miss_tracker i_miss_tracker (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic try_miss(input logic [ADDR_W-1:0] a, input logic [LOC_W-1:0] l,
                          input logic [REG_W-1:0] r, input logic [OFF_W-1:0] o, output bit rdy);
    @(negedge clk);
    miss_addr = a; miss_loc = l; miss_reg = r; miss_off = o; miss_valid = 1;
    #1 rdy = miss_ready;
    @(posedge clk);
    #1 miss_valid = 0;
  endtask

  task automatic take_req(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a, input string tag);
    @(negedge clk);
    chk(req_valid == 1, {tag, " req_valid"}, req_valid, 1);
    chk(req_id == id, {tag, " req_id"}, req_id, id);
    chk(req_addr == a, {tag, " req_addr"}, req_addr, a);
    req_ready = 1;
    @(posedge clk);
    #1 req_ready = 0;
  endtask

  task automatic give_fill(input logic [ID_W-1:0] id);
    @(negedge clk);
    chk(fill_ready == 1, "R9 fill_ready idle", fill_ready, 1);
    fill_valid = 1; fill_id = id;
    @(posedge clk);
    #1 fill_valid = 0;
  endtask

  task automatic pop(input logic [REG_W-1:0] r, input logic [OFF_W-1:0] o,
                     input logic [LOC_W-1:0] l, input bit last, input string tag);
    @(negedge clk);
    chk(rel_valid == 1, {tag, " rel_valid"}, rel_valid, 1);
    chk(rel_reg == r, {tag, " rel_reg"}, rel_reg, r);
    chk(rel_off == o, {tag, " rel_off"}, rel_off, o);
    chk(rel_loc == l, {tag, " rel_loc"}, rel_loc, l);
    chk(rel_last == last, {tag, " rel_last"}, rel_last, last);
    rel_ready = 1;
    @(posedge clk);
    #1 rel_ready = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_valid == 0, "R1 req_valid", req_valid, 0);
    chk(rel_valid == 0, "R1 rel_valid", rel_valid, 0);
    chk(fill_ready == 1, "R1 fill_ready", fill_ready, 1);
    chk(miss_ready == 1, "R1 miss_ready", miss_ready, 1);
  endtask

  task automatic t_merge_and_drain;
    bit rdy;
    try_miss(26'h100, 10'd5, 5'd3, 2'd1, rdy);
    chk(rdy, "R2 primary accepted", rdy, 1);
    @(negedge clk);
    chk(req_valid == 1 && req_id == 0 && req_addr == 26'h100, "R2 request raised", req_addr, 26'h100);
    try_miss(26'h100, 10'd5, 5'd7, 2'd2, rdy);
    chk(rdy, "R3 secondary accepted", rdy, 1);
    try_miss(26'h100, 10'd5, 5'd9, 2'd0, rdy);
    chk(rdy, "R3 secondary accepted", rdy, 1);
    try_miss(26'h100, 10'd5, 5'd12, 2'd3, rdy);
    chk(rdy, "R3 secondary accepted", rdy, 1);
    take_req(2'd0, 26'h100, "R2");
    @(negedge clk);
    chk(req_valid == 0, "R3 no extra request", req_valid, 0);
    try_miss(26'h100, 10'd5, 5'd14, 2'd1, rdy);
    chk(!rdy, "R5 full target list stalls", rdy, 0);
    give_fill(2'd0);
    @(negedge clk);
    chk(fill_ready == 0, "R9 fill_ready while draining", fill_ready, 0);
    try_miss(26'h100, 10'd6, 5'd20, 2'd0, rdy);
    chk(rdy, "R8 miss during drain accepted", rdy, 1);
    pop(5'd3, 2'd1, 10'd5, 0, "R10 R6 held first target");
    pop(5'd7, 2'd2, 10'd5, 0, "R6 second");
    pop(5'd9, 2'd0, 10'd5, 0, "R6 third");
    pop(5'd12, 2'd3, 10'd5, 1, "R6 fourth");
    @(negedge clk);
    chk(rel_valid == 0, "R6 drain ended", rel_valid, 0);
    take_req(2'd1, 26'h100, "R8 new primary");
    give_fill(2'd1);
    pop(5'd20, 2'd0, 10'd6, 1, "R8 released");
  endtask

  task automatic t_capacity;
    bit rdy;
    for (int k = 0; k < 4; k++) begin
      try_miss(26'h200 + 26'(k) * 26'h100, 10'(k + 1), 5'(k + 1), 2'd0, rdy);
      chk(rdy, "R4 entry allocated", rdy, 1);
    end
    try_miss(26'h600, 10'd9, 5'd9, 2'd0, rdy);
    chk(!rdy, "R4 primary stalled when full", rdy, 0);
    try_miss(26'h200, 10'd1, 5'd8, 2'd3, rdy);
    chk(rdy, "R4 secondary accepted when full", rdy, 1);
    for (int k = 0; k < 4; k++)
      take_req(ID_W'(k), 26'h200 + 26'(k) * 26'h100, "R2 order");
    give_fill(2'd2);
    pop(5'd3, 2'd0, 10'd3, 1, "R6 single target");
    @(negedge clk);
    chk(req_valid == 0, "R7 no request before new miss", req_valid, 0);
    try_miss(26'h400, 10'd3, 5'd11, 2'd1, rdy);
    chk(rdy, "R7 freed entry reused", rdy, 1);
    take_req(2'd2, 26'h400, "R7 refetch");
    give_fill(2'd0);
    pop(5'd1, 2'd0, 10'd1, 0, "R3 merged order");
    pop(5'd8, 2'd3, 10'd1, 1, "R3 merged order");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_merge_and_drain();
    t_capacity();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule